// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block drives the external memory pins of a small 8-bit controller core. Its time base is the machine cycle, which lasts twelve oscillator clocks. Each machine cycle is either a code-fetch cycle or a data cycle.

A code-fetch cycle is split into two six-clock halves. Each half reads one program byte over a multiplexed bus. The low address byte is put on the bus and marked by an address-latch pulse. The bus is then released, and an active-low program-read strobe brings the byte in.

A data cycle does one external data read or write in the same twelve clocks. It has a single address-latch pulse and no program-read strobe. An active-low read or write strobe, six clocks wide, moves the byte. The high address byte comes either from the upper half of a 16-bit data address or from a software-held port value, as the request chooses.

Phase n (0..11) of a machine cycle is the n-th clock period in which its pin values are visible. All request inputs and the first fetch address are sampled at the rising edge that makes phase 11 of the previous cycle visible. The second fetch address is sampled at the edge that makes phase 5 visible. After reset, the first rising edge with `rst` low is a sampling edge, and phase 0 appears one clock later.

Top module: `xmem_bus_sequencer`

## Requirements
- R1: While `rst` is high, and in the clock period after the first sampling edge, `ale`=1, `psenN`=1, `rdN`=1, `wrN`=1 and `adOe`=0 (reset is synchronous).
- R2: In a fetch cycle, `ale` is 1 in phases 0-1 and 6-7 and 0 in every other phase, so it pulses twice per machine cycle.
- R3: In a fetch cycle, `adOe`=1 and `adOut` equals the low byte of that half's fetch address in phases 0-2 and 6-8. This keeps the low address on the bus for one clock after `ale` falls.
- R4: In a fetch cycle, `psenN` is 0 in phases 3-5 and 9-11 and 1 otherwise, and `adOe` is 0 whenever `psenN` is 0.
- R5: When `psenN` rises, `adIn` is captured into `fetchData`, and `fetchValid` is 1 for that one clock. During a fetch half, `hiAddr` is the upper byte of that half's fetch address.
- R6: A cycle is a data cycle when `memReq` is 1 at its sampling edge. Then `ale` is 1 only in phases 0-1 and `psenN` stays 1 for all twelve phases.
- R7: In a data cycle, the selected strobe (`wrN` if `memWrite`=1, else `rdN`) is 0 in phases 5-10, six clocks starting three clocks after `ale` falls. The other strobe stays 1.
- R8: In a data cycle, `adOut` carries the low data address with `adOe`=1 in phases 0-2. On a write, `adOut`=`wrData` with `adOe`=1 in phases 4-11. On a read, `adOe` is 0 in phases 3-11 and `adIn` is captured into `rdData` as `rdN` rises. `dataDone` is 1 in phase 11 of every data cycle.
- R9: In a data cycle, `hiAddr` equals `memAddr[15:8]` when `memWide`=1 and `p2Reg` when `memWide`=0, for all twelve phases.
- R10: `memReq`, `memWrite` and `p2Reg` act only at the sampling edge. A request raised and dropped within a fetch cycle leaves its pins unchanged, and a change of `p2Reg` during a data cycle leaves `hiAddr` unchanged.
- R11: Reset asserted in the middle of a strobe returns `ale`=1, `psenN`=`rdN`=`wrN`=1, `adOe`=0 and `dataDone`=0 at the next rising edge.
- R12: At most one of `psenN`, `rdN`, `wrN` is 0 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchAddr | input | 16 | Program address for the next fetch half |
| memReq | input | 1 | Request a data cycle for the next machine cycle |
| memWrite | input | 1 | 1 = data write, 0 = data read |
| memWide | input | 1 | 1 = 16-bit data address, 0 = 8-bit address with `p2Reg` as high byte |
| memAddr | input | 16 | Data address |
| wrData | input | 8 | Write data byte |
| p2Reg | input | 8 | Port register value used as high byte in 8-bit mode |
| adIn | input | 8 | Multiplexed bus input from the pads |
| ale | output | 1 | Address latch strobe, active high |
| psenN | output | 1 | Program read strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| adOut | output | 8 | Multiplexed bus output value |
| adOe | output | 1 | Output enable for `adOut` |
| hiAddr | output | 8 | High address byte |
| fetchData | output | 8 | Last captured program byte |
| fetchValid | output | 1 | One-clock pulse when `fetchData` is updated |
| rdData | output | 8 | Last captured data byte |
| dataDone | output | 1 | One-clock pulse at the end of a data cycle |

## Verification
The hardest case to reach from the ports is a reset that lands inside a data strobe, while the read strobe is low and the bus is released. The stimulus starts a read cycle from a known reset alignment and counts clocks into phase 6. It asserts reset there, checks that every strobe releases without a capture pulse, and then restarts a clean sequence. The stimulus also moves `memReq` and `p2Reg` between sampling edges, and runs data cycles back to back. This shows that these inputs matter only at the boundary and that both halves lose their second address pulse.

// File: rtl/xmem_seq_pkg.sv
package xmem_seq_pkg;

  // Per-clock control word passed from the phase controller to the datapath
  typedef struct packed {
    logic loadFetch;   // sample fetch address this edge
    logic loadData;    // sample data request fields this edge
    logic ale;         // address latch level for next pin period
    logic psen;        // program read strobe active
    logic rd;          // data read strobe active
    logic wr;          // data write strobe active
    logic driveAddr;   // put low address on the bus
    logic driveWdata;  // put write data on the bus
    logic useData;     // address source is the data request
  } xmemStrobes_t;

endpackage

// File: rtl/xmem_seq_ctrl.sv
module xmem_seq_ctrl
  import xmem_seq_pkg::*;
#(
  parameter int HALF     = 6,
  parameter int ALE_W    = 2,
  parameter int PSEN_OFS = 3,
  parameter int PSEN_W   = 3,
  parameter int STB_OFS  = 5,
  parameter int STB_W    = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         memReq,
  input  logic         memWrite,
  output xmemStrobes_t st
);

  localparam int CYCLE = 2 * HALF;
  localparam int PH_W  = $clog2(CYCLE);
  localparam logic [PH_W-1:0] LAST_PH  = PH_W'(CYCLE - 1);
  localparam logic [PH_W-1:0] MID_PH   = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0] HALF_PH  = PH_W'(HALF);
  localparam logic [PH_W-1:0] ALE_END  = PH_W'(ALE_W);
  localparam logic [PH_W-1:0] PSEN_LO  = PH_W'(PSEN_OFS);
  localparam logic [PH_W-1:0] PSEN_HI  = PH_W'(PSEN_OFS + PSEN_W);
  localparam logic [PH_W-1:0] STB_LO   = PH_W'(STB_OFS);
  localparam logic [PH_W-1:0] STB_HI   = PH_W'(STB_OFS + STB_W);
  localparam logic [PH_W-1:0] WDAT_LO  = PH_W'(STB_OFS - 1);

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] subPhase;
  logic            idle;
  logic            isData;
  logic            isWrite;
  logic            inStrobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= LAST_PH;
      idle    <= 1'b1;
      isData  <= 1'b0;
      isWrite <= 1'b0;
    end else begin
      if (phase == LAST_PH) begin
        phase   <= '0;
        idle    <= 1'b0;
        isData  <= memReq;
        isWrite <= memReq & memWrite;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_comb begin
    subPhase = (phase >= HALF_PH) ? (phase - HALF_PH) : phase;
    inStrobe = (phase >= STB_LO) && (phase < STB_HI);
    st = '0;
    st.loadFetch = (phase == LAST_PH) || (phase == MID_PH);
    st.loadData  = (phase == LAST_PH);
    if (idle) begin
      st.ale = 1'b1;
    end else if (isData) begin
      st.useData    = 1'b1;
      st.ale        = phase < ALE_END;
      st.driveAddr  = phase <= ALE_END;
      st.rd         = inStrobe && !isWrite;
      st.wr         = inStrobe && isWrite;
      st.driveWdata = isWrite && (phase >= WDAT_LO);
    end else begin
      st.ale       = subPhase < ALE_END;
      st.driveAddr = subPhase <= ALE_END;
      st.psen      = (subPhase >= PSEN_LO) && (subPhase < PSEN_HI);
    end
  end

endmodule

// File: rtl/xmem_seq_dpath.sv
module xmem_seq_dpath
  import xmem_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  xmemStrobes_t             st,
  input  logic [ADDR_W-1:0]        fetchAddr,
  input  logic                     memWide,
  input  logic [ADDR_W-1:0]        memAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [ADDR_W-DATA_W-1:0] p2Reg,
  input  logic [DATA_W-1:0]        adIn,
  output logic                     ale,
  output logic                     psenN,
  output logic                     rdN,
  output logic                     wrN,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  output logic [ADDR_W-DATA_W-1:0] hiAddr,
  output logic [DATA_W-1:0]        fetchData,
  output logic                     fetchValid,
  output logic [DATA_W-1:0]        rdData,
  output logic                     dataDone
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] fetchAddrQ;
  logic [ADDR_W-1:0] memAddrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [HI_W-1:0]   p2Q;
  logic              wideQ;
  logic              fetchRise;
  logic              readRise;
  logic              writeRise;
  logic [HI_W-1:0]   hiNext;
  logic [DATA_W-1:0] busNext;

  assign fetchRise = !psenN && !st.psen;
  assign readRise  = !rdN && !st.rd;
  assign writeRise = !wrN && !st.wr;

  always_comb begin
    if (st.useData) hiNext = wideQ ? memAddrQ[ADDR_W-1:DATA_W] : p2Q;
    else            hiNext = fetchAddrQ[ADDR_W-1:DATA_W];
    if (st.driveAddr)
      busNext = st.useData ? memAddrQ[DATA_W-1:0] : fetchAddrQ[DATA_W-1:0];
    else if (st.driveWdata)
      busNext = wdataQ;
    else
      busNext = '0;
  end

  // Request latches
  always_ff @(posedge clk) begin
    if (rst) begin
      fetchAddrQ <= '0;
      memAddrQ   <= '0;
      wdataQ     <= '0;
      p2Q        <= '0;
      wideQ      <= 1'b0;
    end else begin
      if (st.loadFetch) fetchAddrQ <= fetchAddr;
      if (st.loadData) begin
        memAddrQ <= memAddr;
        wdataQ   <= wrData;
        p2Q      <= p2Reg;
        wideQ    <= memWide;
      end
    end
  end

  // Pin registers and capture
  always_ff @(posedge clk) begin
    if (rst) begin
      ale        <= 1'b1;
      psenN      <= 1'b1;
      rdN        <= 1'b1;
      wrN        <= 1'b1;
      adOut      <= '0;
      adOe       <= 1'b0;
      hiAddr     <= '0;
      fetchData  <= '0;
      fetchValid <= 1'b0;
      rdData     <= '0;
      dataDone   <= 1'b0;
    end else begin
      ale        <= st.ale;
      psenN      <= !st.psen;
      rdN        <= !st.rd;
      wrN        <= !st.wr;
      adOut      <= busNext;
      adOe       <= st.driveAddr || st.driveWdata;
      hiAddr     <= hiNext;
      fetchValid <= fetchRise;
      dataDone   <= readRise || writeRise;
      if (fetchRise) fetchData <= adIn;
      if (readRise)  rdData    <= adIn;
    end
  end

endmodule

// File: rtl/xmem_bus_sequencer.sv
module xmem_bus_sequencer
  import xmem_seq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int HALF     = 6,
  parameter int ALE_W    = 2,
  parameter int PSEN_OFS = 3,
  parameter int PSEN_W   = 3,
  parameter int STB_OFS  = 5,
  parameter int STB_W    = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        fetchAddr,
  input  logic                     memReq,
  input  logic                     memWrite,
  input  logic                     memWide,
  input  logic [ADDR_W-1:0]        memAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [ADDR_W-DATA_W-1:0] p2Reg,
  input  logic [DATA_W-1:0]        adIn,
  output logic                     ale,
  output logic                     psenN,
  output logic                     rdN,
  output logic                     wrN,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  output logic [ADDR_W-DATA_W-1:0] hiAddr,
  output logic [DATA_W-1:0]        fetchData,
  output logic                     fetchValid,
  output logic [DATA_W-1:0]        rdData,
  output logic                     dataDone
);

  xmemStrobes_t strobes;

  xmem_seq_ctrl #(
    .HALF(HALF), .ALE_W(ALE_W), .PSEN_OFS(PSEN_OFS), .PSEN_W(PSEN_W),
    .STB_OFS(STB_OFS), .STB_W(STB_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .memReq(memReq), .memWrite(memWrite), .st(strobes)
  );

  xmem_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst(rst), .st(strobes),
    .fetchAddr(fetchAddr), .memWide(memWide), .memAddr(memAddr),
    .wrData(wrData), .p2Reg(p2Reg), .adIn(adIn),
    .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN),
    .adOut(adOut), .adOe(adOe), .hiAddr(hiAddr),
    .fetchData(fetchData), .fetchValid(fetchValid),
    .rdData(rdData), .dataDone(dataDone)
  );

endmodule

// File: rtl/xmem_seq_checker.sv
module xmem_seq_checker #(
  parameter int HI_W  = 8,
  parameter int STB_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            ale,
  input logic            psenN,
  input logic            rdN,
  input logic            wrN,
  input logic            adOe,
  input logic [HI_W-1:0] hiAddr
);

  localparam int CW = $clog2(STB_W + 2);

  logic [CW-1:0] lowCnt;

  always_ff @(posedge clk) begin
    if (rst) lowCnt <= '0;
    else if (!rdN || !wrN) lowCnt <= lowCnt + 1'b1;
    else lowCnt <= '0;
  end

  AST_ALE_TWO_WIDE: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> (ale ##1 !ale));  // R2

  AST_PSEN_AFTER_ALE: assert property (@(posedge clk) disable iff (rst)
    $fell(psenN) |-> (!$past(ale) && $past(ale, 2)));  // R4

  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (!psenN || !rdN) |-> !adOe);  // R4

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (rdN && wrN && lowCnt != '0) |-> (lowCnt == CW'(STB_W)));  // R7

  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(wrN) |-> adOe);  // R8

  AST_HI_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!rdN || !wrN) |-> $stable(hiAddr));  // R9

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({!psenN, !rdN, !wrN}));  // R12

endmodule

bind xmem_bus_sequencer xmem_seq_checker #(
  .HI_W(ADDR_W - DATA_W), .STB_W(STB_W)
) u_xmemChk (
  .clk(clk), .rst(rst), .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN),
  .adOe(adOe), .hiAddr(hiAddr)
);

// File: tb/test_xmem_bus_sequencer.sv
`timescale 1ns/1ps
module test_xmem_bus_sequencer;

  typedef struct packed {
    logic        isReq;
    logic        isWr;
    logic        wide;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  p2;
    logic [15:0] fa0;
    logic [15:0] fa1;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h00, 16'h1234, 16'h1235},
    '{1'b1, 1'b0, 1'b1, 16'hA55A, 8'h00, 8'h77, 16'h0000, 16'h0000},
    '{1'b1, 1'b1, 1'b1, 16'h0F80, 8'hC9, 8'h10, 16'h0000, 16'h0000},
    '{1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h00, 16'hFFFE, 16'hFFFF},
    '{1'b1, 1'b0, 1'b0, 16'h3344, 8'h00, 8'hE1, 16'h0000, 16'h0000},
    '{1'b1, 1'b1, 1'b0, 16'h00FF, 8'h5A, 8'h02, 16'h0000, 16'h0000},
    '{1'b1, 1'b0, 1'b1, 16'h8001, 8'h00, 8'h3C, 16'h0000, 16'h0000},
    '{1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h00, 16'h0000, 16'h0001}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] fetchAddr = '0;
  logic        memReq = 1'b0;
  logic        memWrite = 1'b0;
  logic        memWide = 1'b0;
  logic [15:0] memAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  p2Reg = '0;
  logic [7:0]  adIn;
  logic        ale, psenN, rdN, wrN, adOe, fetchValid, dataDone;
  logic [7:0]  adOut, hiAddr, fetchData, rdData;

  int   checks = 0;
  int   errors = 0;
  logic finished = 1'b0;
  logic pendFetch = 1'b0;
  logic [7:0] pendByte = '0;
  logic [7:0] latchLo = '0;

  always #2 clk = ~clk;

  function automatic logic [7:0] codeByte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] dataByte(input logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h11;
  endfunction

  // External memory model: latches the low address while the latch strobe is high
  always @(negedge clk) if (ale && adOe) latchLo <= adOut;
  assign adIn = !psenN ? codeByte({hiAddr, latchLo}) :
                (!rdN ? dataByte({hiAddr, latchLo}) : 8'h00);

  xmem_bus_sequencer i_xmem_bus_sequencer (
    .clk(clk), .rst(rst), .fetchAddr(fetchAddr), .memReq(memReq),
    .memWrite(memWrite), .memWide(memWide), .memAddr(memAddr),
    .wrData(wrData), .p2Reg(p2Reg), .adIn(adIn),
    .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN), .adOut(adOut),
    .adOe(adOe), .hiAddr(hiAddr), .fetchData(fetchData),
    .fetchValid(fetchValid), .rdData(rdData), .dataDone(dataDone)
  );

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic setInputs(input vec_t v);
    memReq    = v.isReq;
    memWrite  = v.isWr;
    memWide   = v.wide;
    memAddr   = v.addr;
    wrData    = v.wdata;
    p2Reg     = v.p2;
    fetchAddr = v.fa0;
  endtask

  task automatic checkIdle(input string tag);
    chk(tag, "ale", 16'(ale), 16'h1);
    chk(tag, "psenN", 16'(psenN), 16'h1);
    chk(tag, "rdN", 16'(rdN), 16'h1);
    chk(tag, "wrN", 16'(wrN), 16'h1);
    chk(tag, "adOe", 16'(adOe), 16'h0);
  endtask

  task automatic checkPhase(input vec_t v, input int n);
    int s;
    logic [15:0] fa;
    logic eAle, ePsen, eRd, eWr, eOe, inStb;
    logic [7:0] eAd, eHi;
    s  = n % 6;
    fa = (n < 6) ? v.fa0 : v.fa1;
    if (!v.isReq) begin
      eAle = (s < 2); ePsen = !(s >= 3); eRd = 1'b1; eWr = 1'b1;
      eOe = (s <= 2); eAd = fa[7:0]; eHi = fa[15:8];
      chk("R2", $sformatf("fetch ale ph%0d", n), 16'(ale), 16'(eAle));
      chk("R4", $sformatf("fetch psenN ph%0d", n), 16'(psenN), 16'(ePsen));
      chk("R10", $sformatf("fetch rdN/wrN ph%0d", n), 16'({rdN, wrN}), 16'({eRd, eWr}));
      chk("R3", $sformatf("fetch adOe ph%0d", n), 16'(adOe), 16'(eOe));
      if (eOe) chk("R3", $sformatf("fetch adOut ph%0d", n), 16'(adOut), 16'(eAd));
      chk("R5", $sformatf("fetch hiAddr ph%0d", n), 16'(hiAddr), 16'(eHi));
    end else begin
      inStb = (n >= 5) && (n <= 10);
      eAle = (n < 2); ePsen = 1'b1;
      eRd = !(inStb && !v.isWr); eWr = !(inStb && v.isWr);
      eOe = (n <= 2) || (v.isWr && n >= 4);
      eAd = (n <= 2) ? v.addr[7:0] : v.wdata;
      eHi = v.wide ? v.addr[15:8] : v.p2;
      chk("R6", $sformatf("data ale ph%0d", n), 16'(ale), 16'(eAle));
      chk("R6", $sformatf("data psenN ph%0d", n), 16'(psenN), 16'(ePsen));
      chk("R7", $sformatf("data rdN/wrN ph%0d", n), 16'({rdN, wrN}), 16'({eRd, eWr}));
      chk("R8", $sformatf("data adOe ph%0d", n), 16'(adOe), 16'(eOe));
      if (eOe) chk("R8", $sformatf("data adOut ph%0d", n), 16'(adOut), 16'(eAd));
      chk((n >= 3) ? "R10" : "R9", $sformatf("data hiAddr ph%0d", n), 16'(hiAddr), 16'(eHi));
    end
    chk("R12", $sformatf("strobe count ph%0d", n),
        16'($countones({!psenN, !rdN, !wrN}) <= 1), 16'h1);
  endtask

  task automatic runVec(input vec_t v, input logic haveNext, input vec_t nxt,
                        input int stopAt);
    logic [15:0] eff;
    eff = v.wide ? v.addr : {v.p2, v.addr[7:0]};
    for (int n = 0; n < stopAt; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (n == 0) begin
        if (pendFetch) begin
          chk("R5", "second-half fetchValid", 16'(fetchValid), 16'h1);
          chk("R5", "second-half fetchData", 16'(fetchData), 16'(pendByte));
        end else begin
          chk("R6", "no fetch capture at cycle start", 16'(fetchValid), 16'h0);
        end
        pendFetch = 1'b0;
      end
      checkPhase(v, n);
      if (!v.isReq) begin
        if (n == 2) begin memReq = 1'b1; memWrite = 1'b1; end
        if (n == 8) memReq = 1'b0;
        if (n == 4) fetchAddr = v.fa1;
        if (n == 6) begin
          chk("R5", "first-half fetchValid", 16'(fetchValid), 16'h1);
          chk("R5", "first-half fetchData", 16'(fetchData), 16'(codeByte(v.fa0)));
        end
        if (n == 11) begin pendFetch = 1'b1; pendByte = codeByte(v.fa1); end
      end else begin
        if (n == 3) p2Reg = ~v.p2;
        if (n == 11) begin
          chk("R8", "dataDone", 16'(dataDone), 16'h1);
          if (!v.isWr) chk("R8", "rdData", 16'(rdData), 16'(dataByte(eff)));
        end
      end
      if (n == 10 && haveNext) setInputs(nxt);
    end
  endtask

  task automatic doReset(input vec_t first);
    rst = 1'b1;
    pendFetch = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkIdle("R1");
    setInputs(first);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checkIdle("R1");
  endtask

  initial begin
    doReset(VECS[0]);
    for (int i = 0; i < NV; i++)
      runVec(VECS[i], i < NV - 1, VECS[(i < NV - 1) ? i + 1 : i], 12);

    // R11: reset lands in phase 6 of a read, with rdN low and the bus released
    doReset(VECS[1]);
    runVec(VECS[1], 1'b0, VECS[1], 7);
    chk("R11", "rdN low before abort", 16'(rdN), 16'h0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkIdle("R11");
    chk("R11", "dataDone after abort", 16'(dataDone), 16'h0);

    // Restart after the abort: narrow write, then fetch
    doReset(VECS[5]);
    runVec(VECS[5], 1'b1, VECS[0], 12);
    runVec(VECS[0], 1'b0, VECS[0], 12);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule